// File: doc/BRIEF.md
# Asynchronous Word Framer with Payload Clock Regeneration

This block takes a demodulated serial bit stream, nominally at 1200 bit/s, together with a flag that says whether a valid carrier is present. It locates each asynchronous character on the line. A character is a low start bit, eight payload bits sent least significant first, and a high stop bit. For the eight payload bits only, it produces a regenerated clock. Each rising edge of that clock sits in the middle of a payload bit cell. A shift register or a microcontroller can therefore clock in the payload on the rising edge without any timing logic of its own.

At the end of every well-formed character, the block drives an active-low ready strobe. This strobe can serve as an interrupt, or it can trigger a parallel load. The block also passes the line through to its data output after re-timing it. When the carrier flag is inactive, the data output is held high and no clock or ready pulse is produced.

The bit period is a parameter counted in system clocks. At the default of 208333 clocks per bit, a 250 MHz system clock gives 1200 bit/s. Both asynchronous inputs pass through two-stage synchronizers. Every timing figure below is measured at the synchronized input.

Top module: `async_framer`

## Requirements
- R1: The value on `data_out` at each rising edge of `data_clk` is the payload bit of the current character. Bits appear in line order, least significant bit first. The eight values taken together rebuild the transmitted byte.
- R2: A character with a high stop bit produces exactly eight rising edges of `data_clk`.
- R3: The first rising edge of `data_clk` follows the start-bit falling edge on `rx_bit` by 1.5 bit periods, plus a fixed synchronizer latency of at most 4 clocks. Each later rising edge in the same character follows the previous one by exactly one bit period.
- R4: `data_clk` is never high while `ready_n` is low. No clock edge falls in the start bit or the stop bit.
- R5: `ready_n` goes low exactly one bit period after the eighth rising edge of `data_clk`, which is the centre of the stop bit. It stays low for half a bit period.
- R6: While `carrier_ok` is low (after synchronizer latency), the following all hold:
  - `data_out` is high.
  - `data_clk` is low.
  - `ready_n` is high.
  - Any character in progress is abandoned.
- R7: A low pulse on `rx_bit` that returns high before the half-bit confirmation sample is rejected. It produces no clock edge and no ready pulse.
- R8: Each high phase of `data_clk` lasts half a bit period.
- R9: A character whose stop bit is low still produces its eight clock edges but no ready pulse. The framer then waits for a fresh falling edge, and the next character is received normally.
- R10: During and immediately after reset, `data_out` is 1, `data_clk` is 0 and `ready_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_bit | input | 1 | Demodulated serial line, idle high |
| carrier_ok | input | 1 | High while a valid carrier is present |
| data_out | output | 1 | Re-timed serial line, forced high without carrier |
| data_clk | output | 1 | Regenerated payload clock, rising at bit centres |
| ready_n | output | 1 | Active-low end-of-character strobe |

## Verification
The assertions take two things for granted:
- The line holds each bit steady for a whole bit period, so the centre samples see settled values.
- Characters are separated far enough apart that the half-bit ready strobe ends before the next centre sample.

The stimulus meets these assumptions. Every character is driven on the falling clock edge at exactly the nominal bit period, with at least one idle bit period between characters. Glitches are kept shorter than half a bit, and carrier changes occur only while the line is idle or between whole bits.

// File: rtl/fr_pkg.sv
package fr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } fr_state_e;

    localparam int unsigned PAYLOAD_BITS = 8;
    localparam int unsigned IDX_W        = $clog2(PAYLOAD_BITS);

    typedef struct packed {
        fr_state_e        state;
        logic [IDX_W-1:0] idx;
        logic             line_prev;
        logic             dout;
    } fr_ctrl_t;

endpackage

// File: rtl/fr_sync.sv
module fr_sync #(
    parameter int unsigned N       = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] in_async,
    output logic [N-1:0] out_sync
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic s1_q, s2_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q <= RST_VAL[g];
                s2_q <= RST_VAL[g];
            end else begin
                s1_q <= in_async[g];
                s2_q <= s1_q;
            end
        end
        assign out_sync[g] = s2_q;
    end
endmodule

// File: rtl/fr_bit_timer.sv
module fr_bit_timer #(
    parameter int unsigned CPB = 208333
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic at_half,
    output logic at_full
);
    localparam int unsigned HALF = CPB / 2;
    localparam int unsigned CW   = $clog2(CPB + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = clr ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign at_half = (cnt_q == CW'(HALF - 1));
    assign at_full = (cnt_q == CW'(CPB - 1));
endmodule

// File: rtl/fr_pulse.sv
module fr_pulse #(
    parameter int unsigned WIDTH_CYC   = 4,
    parameter bit          ACTIVE_HIGH = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic kill,
    output logic pulse
);
    localparam int unsigned CW = $clog2(WIDTH_CYC + 1);

    logic          on_d, on_q;
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        on_d  = on_q;
        cnt_d = cnt_q;
        if (kill) begin
            on_d  = 1'b0;
            cnt_d = '0;
        end else if (trig) begin
            on_d  = 1'b1;
            cnt_d = '0;
        end else if (on_q) begin
            if (cnt_q == CW'(WIDTH_CYC - 1)) begin
                on_d  = 1'b0;
                cnt_d = '0;
            end else begin
                cnt_d = cnt_q + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on_q  <= 1'b0;
            cnt_q <= '0;
        end else begin
            on_q  <= on_d;
            cnt_q <= cnt_d;
        end
    end

    if (ACTIVE_HIGH) begin : g_hi
        assign pulse = on_q;
    end else begin : g_lo
        assign pulse = ~on_q;
    end
endmodule

// File: rtl/fr_ctrl.sv
module fr_ctrl
    import fr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_s,
    input  logic car_s,
    input  logic at_half,
    input  logic at_full,
    output logic tmr_clr,
    output logic clk_trig,
    output logic rdy_trig,
    output logic hunting,
    output logic dout
);
    fr_ctrl_t cur_q, nxt_d;

    always_comb begin
        nxt_d          = cur_q;
        nxt_d.line_prev = line_s;
        nxt_d.dout     = car_s ? line_s : 1'b1;
        tmr_clr        = 1'b0;
        clk_trig       = 1'b0;
        rdy_trig       = 1'b0;

        if (!car_s) begin
            nxt_d.state = ST_IDLE;
            nxt_d.idx   = '0;
            tmr_clr     = 1'b1;
        end else begin
            unique case (cur_q.state)
                ST_IDLE: begin
                    tmr_clr = 1'b1;
                    if (cur_q.line_prev && !line_s) begin
                        nxt_d.state = ST_START;
                    end
                end
                ST_START: begin
                    if (at_half) begin
                        tmr_clr = 1'b1;
                        // confirm start bit at its centre, else treat as glitch
                        nxt_d.state = line_s ? ST_IDLE : ST_DATA;
                        nxt_d.idx   = '0;
                    end
                end
                ST_DATA: begin
                    if (at_full) begin
                        tmr_clr  = 1'b1;
                        clk_trig = 1'b1;
                        if (cur_q.idx == IDX_W'(PAYLOAD_BITS - 1)) begin
                            nxt_d.state = ST_STOP;
                        end else begin
                            nxt_d.idx = cur_q.idx + IDX_W'(1);
                        end
                    end
                end
                ST_STOP: begin
                    if (at_full) begin
                        tmr_clr     = 1'b1;
                        rdy_trig    = line_s;   // low stop bit: framing error
                        nxt_d.state = ST_IDLE;
                    end
                end
                default: begin
                    nxt_d.state = ST_IDLE;
                    tmr_clr     = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state     <= ST_IDLE;
            cur_q.idx       <= '0;
            cur_q.line_prev <= 1'b1;
            cur_q.dout      <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign hunting = (cur_q.state == ST_IDLE);
    assign dout    = cur_q.dout;
endmodule

// File: rtl/async_framer.sv
module async_framer #(
    parameter int unsigned CLKS_PER_BIT = 208333
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_bit,
    input  logic carrier_ok,
    output logic data_out,
    output logic data_clk,
    output logic ready_n
);
    localparam int unsigned HALF_BIT = CLKS_PER_BIT / 2;

    logic [1:0] raw_in, sync_out;
    logic       line_s, car_s;
    logic       tmr_clr, at_half, at_full;
    logic       clk_trig, rdy_trig, hunting;

    assign raw_in = {carrier_ok, rx_bit};

    fr_sync #(.N(2), .RST_VAL(2'b01)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_async (raw_in),
        .out_sync (sync_out)
    );

    assign line_s = sync_out[0];
    assign car_s  = sync_out[1];

    fr_bit_timer #(.CPB(CLKS_PER_BIT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .at_half (at_half),
        .at_full (at_full)
    );

    fr_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_s   (line_s),
        .car_s    (car_s),
        .at_half  (at_half),
        .at_full  (at_full),
        .tmr_clr  (tmr_clr),
        .clk_trig (clk_trig),
        .rdy_trig (rdy_trig),
        .hunting  (hunting),
        .dout     (data_out)
    );

    fr_pulse #(.WIDTH_CYC(HALF_BIT), .ACTIVE_HIGH(1'b1)) u_clk_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (clk_trig),
        .kill  (~car_s),
        .pulse (data_clk)
    );

    fr_pulse #(.WIDTH_CYC(HALF_BIT), .ACTIVE_HIGH(1'b0)) u_rdy_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (rdy_trig),
        .kill  (~car_s),
        .pulse (ready_n)
    );
endmodule

// File: rtl/fr_chk.sv
module fr_chk #(
    parameter int unsigned CPB = 16
) (
    input logic clk,
    input logic rst_n,
    input logic car_s,
    input logic hunting,
    input logic data_out,
    input logic data_clk,
    input logic ready_n
);
    localparam int unsigned HALF = CPB / 2;
    localparam int unsigned HW   = $clog2(CPB + 1) + 1;

    logic [HW-1:0] hi_cnt_q, lo_cnt_q;
    logic [4:0]    rises_q;
    logic          clk_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt_q   <= '0;
            lo_cnt_q   <= '0;
            rises_q    <= '0;
            clk_prev_q <= 1'b0;
        end else begin
            clk_prev_q <= data_clk;
            hi_cnt_q   <= data_clk ? hi_cnt_q + HW'(1) : '0;
            lo_cnt_q   <= !ready_n ? lo_cnt_q + HW'(1) : '0;
            if (hunting)                      rises_q <= '0;
            else if (data_clk && !clk_prev_q) rises_q <= rises_q + 5'd1;
        end
    end

    p_quiet_no_carrier_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !car_s |=> (data_out && !data_clk && ready_n));

    p_no_clk_in_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_clk && !ready_n));

    p_clk_high_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hi_cnt_q <= HW'(HALF));

    p_ready_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lo_cnt_q <= HW'(HALF));

    p_rise_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rises_q <= 5'd8);

    p_eight_before_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_n) |-> (rises_q == 5'd8));
endmodule

bind async_framer fr_chk #(.CPB(CLKS_PER_BIT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .car_s    (car_s),
    .hunting  (hunting),
    .data_out (data_out),
    .data_clk (data_clk),
    .ready_n  (ready_n)
);

// File: tb/async_framer_test.sv
module async_framer_test;
    localparam int CPB  = 16;
    localparam int HALF = CPB / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_bit = 1'b1;
    logic carrier_ok = 1'b0;
    logic data_out, data_clk, ready_n;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    // monitor state
    int   nrise, nrdy, last_rise, start_cyc, hi_start, lo_start, bad_dout;
    logic [7:0] cap;
    bit   abort_word, quiet_chk;
    logic clk_prev = 1'b0, rdy_prev = 1'b1;

    async_framer #(.CLKS_PER_BIT(CPB)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_bit     (rx_bit),
        .carrier_ok (carrier_ok),
        .data_out   (data_out),
        .data_clk   (data_clk),
        .ready_n    (ready_n)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int first_rise_ok(input int dt);
        return (dt >= CPB + HALF) && (dt <= CPB + HALF + 4);
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (data_clk && !clk_prev) begin
                cap = {data_out, cap[7:1]};
                if (nrise == 0)
                    check(first_rise_ok(cyc - start_cyc), "R3 first edge", cyc - start_cyc, CPB + HALF);
                else
                    check(cyc - last_rise == CPB, "R3 spacing", cyc - last_rise, CPB);
                nrise++;
                last_rise = cyc;
                hi_start  = cyc;
            end
            if (!data_clk && clk_prev && !abort_word)
                check(cyc - hi_start == HALF, "R8 high time", cyc - hi_start, HALF);
            if (!ready_n && rdy_prev) begin
                nrdy++;
                lo_start = cyc;
                check(cyc - last_rise == CPB, "R5 ready position", cyc - last_rise, CPB);
                check(data_clk == 1'b0, "R4 clock low at ready", int'(data_clk), 0);
            end
            if (ready_n && !rdy_prev)
                check(cyc - lo_start == HALF, "R5 ready width", cyc - lo_start, HALF);
            if (quiet_chk && (data_out !== 1'b1 || data_clk !== 1'b0 || ready_n !== 1'b1))
                bad_dout++;
        end
        clk_prev = data_clk;
        rdy_prev = ready_n;
    end

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic begin_word();
        nrise = 0;
        nrdy = 0;
        cap = '0;
        start_cyc = cyc;
    endtask

    // drop_at < 0: carrier stays; otherwise carrier is dropped before that payload bit
    task automatic send_word(input logic [7:0] b, input logic stop_v, input int drop_at);
        @(negedge clk);
        begin_word();
        rx_bit = 1'b0;
        wait_neg(CPB);
        for (int i = 0; i < 8; i++) begin
            if (i == drop_at) carrier_ok = 1'b0;
            rx_bit = b[i];
            wait_neg(CPB);
        end
        rx_bit = stop_v;
        wait_neg(CPB);
        rx_bit = 1'b1;
        wait_neg(CPB + int'($urandom_range(0, CPB)));
    endtask

    task automatic good_word(input logic [7:0] b, input string tag);
        send_word(b, 1'b1, -1);
        check(nrise == 8, {tag, " R2 edge count"}, nrise, 8);
        check(cap == b, {tag, " R1 payload"}, int'(cap), int'(b));
        check(nrdy == 1, {tag, " R5 ready count"}, nrdy, 1);
    endtask

    initial begin
        void'($urandom(32'h1f2e3d4c));
        nrise = 0; nrdy = 0; cap = '0; start_cyc = 0; last_rise = 0;
        hi_start = 0; lo_start = 0; bad_dout = 0; abort_word = 0; quiet_chk = 0;

        wait_neg(3);
        check(data_out === 1'b1 && data_clk === 1'b0 && ready_n === 1'b1,
              "R10 reset outputs", {data_out, data_clk, ready_n}, 3'b101);
        rst_n = 1'b1;
        wait_neg(2);
        check(data_out === 1'b1 && data_clk === 1'b0 && ready_n === 1'b1,
              "R10 after reset", {data_out, data_clk, ready_n}, 3'b101);

        carrier_ok = 1'b1;
        wait_neg(2 * CPB);

        good_word(8'h00, "zeros");
        good_word(8'hFF, "ones");
        good_word(8'h55, "alt");
        good_word(8'h80, "msb");
        for (int k = 0; k < 20; k++) good_word(8'($urandom_range(0, 255)), "rand");

        // R7: short glitch rejected
        @(negedge clk);
        begin_word();
        rx_bit = 1'b0;
        wait_neg(HALF - 4);
        rx_bit = 1'b1;
        wait_neg(3 * CPB);
        check(nrise == 0, "R7 glitch edges", nrise, 0);
        check(nrdy == 0, "R7 glitch ready", nrdy, 0);
        good_word(8'hA3, "post-glitch R7");

        // R9: framing error
        send_word(8'h3C, 1'b0, -1);
        check(nrise == 8, "R9 edges on bad stop", nrise, 8);
        check(nrdy == 0, "R9 no ready on bad stop", nrdy, 0);
        wait_neg(CPB);
        good_word(8'hC5, "post-framing R9");

        // R6: carrier absent for a whole word
        carrier_ok = 1'b0;
        wait_neg(4);
        quiet_chk = 1'b1;
        send_word(8'h5A, 1'b1, -1);
        quiet_chk = 1'b0;
        check(nrise == 0, "R6 no edges without carrier", nrise, 0);
        check(nrdy == 0, "R6 no ready without carrier", nrdy, 0);
        check(bad_dout == 0, "R6 outputs quiet", bad_dout, 0);

        // R6: carrier lost mid-word
        carrier_ok = 1'b1;
        wait_neg(2 * CPB);
        abort_word = 1'b1;
        send_word(8'hE7, 1'b1, 4);
        check(nrise <= 4, "R6 edges stop on carrier loss", nrise, 4);
        check(nrdy == 0, "R6 no ready after carrier loss", nrdy, 0);
        check(data_out === 1'b1, "R6 data forced high", int'(data_out), 1);
        abort_word = 1'b0;
        carrier_ok = 1'b1;
        wait_neg(2 * CPB);
        good_word(8'h96, "post-carrier R6");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual 1 expected 0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule